// File: doc/BRIEF.md
# Event Routing Channel

One channel of a peripheral event router. A 7-bit generator index in the channel's configuration word picks one of 127 generator lines; index zero connects nothing. The chosen line reaches the channel output along one of three routes. Two of them are clocked. The synchronous route samples the line in one channel-clock flop. The resynchronized route passes it through a two-flop synchronizer. On both clocked routes an edge detector turns level changes into single-cycle event pulses. The third route is asynchronous: a combinational pass-through with no edge detection.

The channel also drives a clock request for its own clock. The request is either held high whenever the channel is configured and running, or raised only while an event is in flight. A sleep input with a per-channel run-in-sleep bit can stop the channel in low-power modes. Channels whose index is at or above a set limit have no clocked routes and always run asynchronously.

Top module: `evr_channel`

## Requirements
- R1: After reset the configuration reads 0x00008000, `evt_o` is 0 and `clk_req_o` is 0.
- R2: The configuration changes only on a write with all four byte enables set. Any other enable pattern leaves it unchanged. Only bits 15, 14, 11:8 and 6:0 are stored; all other bits read 0.
- R3: Bits 6:0 are the generator index. Index n connects `gen_i[n]`. Index 0 keeps `evt_o` and `clk_req_o` at 0.
- R4: Bits 9:8 select the route: 0 synchronous, 1 resynchronized, 2 asynchronous. On the synchronous route, an edge of the line present at clock edge k gives a pulse on `evt_o` after edge k+1.
- R5: On the resynchronized route, an edge of the line present at clock edge k gives a pulse on `evt_o` after edge k+2.
- R6: Bits 11:10 set the detection mode on the clocked routes: 0 gives no event, 1 rising edges only, 2 falling edges only, 3 both edges. Each detected edge gives a pulse exactly one clock cycle wide.
- R7: On the asynchronous route, `evt_o` follows the selected line combinationally and ignores bits 11:10.
- R8: When CHAN_IDX is SYNC_CAP (12) or higher, the channel uses the asynchronous route whatever bits 9:8 hold.
- R9: Route value 3 is reserved. With it, `evt_o` and `clk_req_o` stay 0.
- R10: While `sleep_i` is high and bit 14 is 0, the channel is stopped: `evt_o` and `clk_req_o` are 0. With bit 14 set, the channel runs normally during sleep.
- R11: With bit 15 at 0, `clk_req_o` is high whenever the channel is running with a nonzero index and a valid route. With bit 15 at 1, on a clocked route `clk_req_o` is high from the cycle the edge is detected through the cycle of its pulse. On the asynchronous route it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration word |
| sleep_i | input | 1 | Idle or standby sleep active |
| gen_i | input | 128 | Event generator lines, bit 0 unused |
| evt_o | output | 1 | Channel event output |
| clk_req_o | output | 1 | Channel clock request |

## Verification
The bench goes after the latency of each clocked route. A resynchronized route built with the same depth as the synchronous one would pulse one cycle early. It also checks the detection modes on random toggling lines, where a swapped rise/fall decode or a stretched pulse shows up at once. Byte-enable filtering is tested with partial writes; a design that accepted them would change the configuration it reads back. Reserved routes, index zero, sleep without run-in-sleep and a high channel index that must ignore the route field are each checked against outputs that must stay quiet or pass straight through. The on-demand request is compared cycle by cycle against the detection window.

// File: rtl/evr_pkg.sv
package evr_pkg;

  localparam int GEN_SEL_W = 7;
  localparam logic [31:0] CFG_RESET = 32'h0000_8000;
  localparam logic [31:0] CFG_MASK  = 32'h0000_CF7F;

  typedef enum logic [1:0] {
    ROUTE_SYNC   = 2'd0,
    ROUTE_RESYNC = 2'd1,
    ROUTE_ASYNC  = 2'd2,
    ROUTE_RSVD   = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    DET_NONE = 2'd0,
    DET_RISE = 2'd1,
    DET_FALL = 2'd2,
    DET_BOTH = 2'd3
  } det_e;

  typedef struct packed {
    logic                 on_demand;
    logic                 run_sleep;
    det_e                 det_mode;
    route_e               route;
    logic [GEN_SEL_W-1:0] gen_sel;
  } chan_cfg_t;

  function automatic chan_cfg_t unpack_cfg(input logic [31:0] w);
    chan_cfg_t c;
    c.on_demand = w[15];
    c.run_sleep = w[14];
    c.det_mode  = det_e'(w[11:10]);
    c.route     = route_e'(w[9:8]);
    c.gen_sel   = w[GEN_SEL_W-1:0];
    return c;
  endfunction

  function automatic logic detect(input det_e m, input logic cur, input logic prev);
    case (m)
      DET_RISE: return cur & ~prev;
      DET_FALL: return ~cur & prev;
      DET_BOTH: return cur ^ prev;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evr_cfg_reg.sv
module evr_cfg_reg
  import evr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] raw_o,
  output chan_cfg_t   cfg_o
);

  logic [31:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= CFG_RESET;
    end else if (wr && (&be)) begin
      word_q <= wdata & CFG_MASK;
    end
  end

  assign raw_o = word_q;
  assign cfg_o = unpack_cfg(word_q);

endmodule

// File: rtl/evr_line_sel.sv
module evr_line_sel #(
  parameter int SEL_W = 7,
  localparam int NUM_LINES = 1 << SEL_W
) (
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 line_o
);

  always_comb begin
    if (sel_i == '0) line_o = 1'b0;
    else             line_o = lines_i[sel_i];
  end

endmodule

// File: rtl/evr_edge_pipe.sv
module evr_edge_pipe
  import evr_pkg::*;
#(
  parameter int RESYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic resync,
  input  det_e mode,
  input  logic line_i,
  output logic hit_o,
  output logic evt_o
);

  logic [RESYNC_STAGES-1:0] chain_q;
  logic                     prev_q;
  logic                     evt_q;
  logic                     cur;

  for (genvar i = 0; i < RESYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst || clr) chain_q[0] <= 1'b0;
        else            chain_q[0] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst || clr) chain_q[i] <= 1'b0;
        else            chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign cur   = resync ? chain_q[RESYNC_STAGES-1] : chain_q[0];
  assign hit_o = detect(mode, cur, prev_q);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      evt_q  <= hit_o;
    end
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/evr_channel.sv
module evr_channel
  import evr_pkg::*;
#(
  parameter int CHAN_IDX      = 0,
  parameter int SYNC_CAP      = 12,
  parameter int RESYNC_STAGES = 2,
  localparam int NUM_GEN      = 1 << GEN_SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               sleep_i,
  input  logic [NUM_GEN-1:0] gen_i,
  output logic               evt_o,
  output logic               clk_req_o
);

  chan_cfg_t cfg;
  route_e    route_eff;
  logic      line;
  logic      running;
  logic      clocked;
  logic      pipe_hit;
  logic      pipe_evt;
  logic      busy;

  evr_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .raw_o (cfg_rdata),
    .cfg_o (cfg)
  );

  evr_line_sel #(.SEL_W(GEN_SEL_W)) u_sel (
    .lines_i (gen_i),
    .sel_i   (cfg.gen_sel),
    .line_o  (line)
  );

  if (CHAN_IDX < SYNC_CAP) begin : g_all_routes
    assign route_eff = cfg.route;
  end else begin : g_async_only
    assign route_eff = ROUTE_ASYNC;
  end

  assign running = (cfg.gen_sel != '0) && (route_eff != ROUTE_RSVD)
                   && !(sleep_i && !cfg.run_sleep);
  assign clocked = (route_eff == ROUTE_SYNC) || (route_eff == ROUTE_RESYNC);

  evr_edge_pipe #(.RESYNC_STAGES(RESYNC_STAGES)) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .clr    (!(running && clocked)),
    .resync (route_eff == ROUTE_RESYNC),
    .mode   (cfg.det_mode),
    .line_i (line),
    .hit_o  (pipe_hit),
    .evt_o  (pipe_evt)
  );

  assign busy      = clocked && (pipe_hit || pipe_evt);
  assign evt_o     = running && (clocked ? pipe_evt : line);
  assign clk_req_o = running && (!cfg.on_demand || busy);

endmodule

// File: rtl/evr_channel_chk.sv
module evr_channel_chk #(
  parameter int CHAN_IDX = 0,
  parameter int SYNC_CAP = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic        sleep_i,
  input logic        evt_o,
  input logic        clk_req_o
);

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_rdata) |-> $past(cfg_wr && cfg_be == 4'hF));

  // R2
  cfg_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & ~32'h0000_CF7F) == 32'h0);

  // R3
  no_gen_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[6:0] == 7'd0 |-> !evt_o && !clk_req_o);

  // R9
  rsvd_route_chk: assert property (@(posedge clk) disable iff (rst)
    (CHAN_IDX < SYNC_CAP) && cfg_rdata[9:8] == 2'b11 |-> !evt_o && !clk_req_o);

  // R10
  sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_i && !cfg_rdata[14] |-> !evt_o && !clk_req_o);

  // R11
  always_on_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[15] && cfg_rdata[6:0] != 7'd0 && !(sleep_i && !cfg_rdata[14])
    && !((CHAN_IDX < SYNC_CAP) && cfg_rdata[9:8] == 2'b11) |-> clk_req_o);

endmodule

bind evr_channel evr_channel_chk #(.CHAN_IDX(CHAN_IDX), .SYNC_CAP(SYNC_CAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .cfg_be    (cfg_be),
  .cfg_rdata (cfg_rdata),
  .sleep_i   (sleep_i),
  .evt_o     (evt_o),
  .clk_req_o (clk_req_o)
);

// File: tb/test_evr_channel.sv
`timescale 1ns/1ps
module test_evr_channel;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_wr = 1'b0;
  logic [3:0]   cfg_be = 4'h0;
  logic [31:0]  cfg_wdata = 32'h0;
  logic [31:0]  rdata_lo, rdata_hi;
  logic         sleep_i = 1'b0;
  logic [127:0] gen_i = '0;
  logic         evt_lo, req_lo, evt_hi, req_hi;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic [6:0] m_sel;
  logic [1:0] m_route, m_det;
  logic       m_od, m_rs;
  logic       v0, v1, v2, v3;

  always #2.5 clk = ~clk;

  evr_channel #(.CHAN_IDX(3)) i_evr_channel (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_lo), .sleep_i(sleep_i), .gen_i(gen_i),
    .evt_o(evt_lo), .clk_req_o(req_lo)
  );

  evr_channel #(.CHAN_IDX(14)) i_evr_channel_hi (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_hi), .sleep_i(sleep_i), .gen_i(gen_i),
    .evt_o(evt_hi), .clk_req_o(req_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_cfg(logic od, logic rs, logic [1:0] det,
                                         logic [1:0] route, logic [6:0] sel);
    return {16'h0, od, rs, 2'b00, det, route, 1'b0, sel};
  endfunction

  function automatic logic det_f(logic [1:0] m, logic cur, logic prev);
    case (m)
      2'd1: return cur & ~prev;
      2'd2: return ~cur & prev;
      2'd3: return cur ^ prev;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic line_f();
    return (m_sel == 7'd0) ? 1'b0 : gen_i[m_sel];
  endfunction

  function automatic logic run_lo();
    return (m_sel != 0) && (m_route != 2'd3) && !(sleep_i && !m_rs);
  endfunction

  function automatic logic run_hi();
    return (m_sel != 0) && !(sleep_i && !m_rs);
  endfunction

  task automatic write_cfg(input logic [3:0] be, input logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  // Run one configuration against random generator activity.
  task automatic run_seg(input logic [31:0] w, input logic slp, input int cycles);
    logic ev, bz;
    m_od = w[15]; m_rs = w[14]; m_det = w[11:10]; m_route = w[9:8]; m_sel = w[6:0];
    gen_i = '0;
    sleep_i = slp;
    write_cfg(4'hF, w);
    repeat (5) @(negedge clk);
    v0 = 0; v1 = 0; v2 = 0; v3 = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i > 0 && (m_route == 2'd0 || m_route == 2'd1 || m_route == 2'd3)) begin
        if (!run_lo()) begin
          ev = 1'b0; bz = 1'b0;
        end else if (m_route == 2'd0) begin
          ev = det_f(m_det, v1, v2); bz = det_f(m_det, v0, v1) | ev;
        end else begin
          ev = det_f(m_det, v2, v3); bz = det_f(m_det, v1, v2) | ev;
        end
        // R4 R5 R6 R9 R10 R3
        chk(m_route == 2'd0 ? "R4 sync event" : "R5 resync event", evt_lo, ev);
        // R11
        chk("R11 clock request", req_lo, run_lo() && (!m_od || bz));
      end
      gen_i = {$urandom, $urandom, $urandom, $urandom};
      #1;
      if (m_route == 2'd2) begin
        // R7
        chk("R7 async pass", evt_lo, run_lo() && line_f());
        chk("R11 async request", req_lo, run_lo() && !m_od);
      end
      // R8
      chk("R8 high channel async", evt_hi, run_hi() && line_f());
      chk("R8 high channel request", req_hi, run_hi() && !m_od);
      @(posedge clk);
      v3 = v2; v2 = v1; v1 = v0; v0 = line_f();
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 reset config", rdata_lo, 32'h0000_8000);
    chk("R1 reset event", evt_lo, 0);
    chk("R1 reset request", req_lo, 0);
    // R2 partial writes
    write_cfg(4'b0111, 32'h0000_FFFF);
    chk("R2 partial write ignored", rdata_lo, 32'h0000_8000);
    write_cfg(4'b0011, 32'h0000_0105);
    chk("R2 halfword write ignored", rdata_lo, 32'h0000_8000);
    write_cfg(4'hF, 32'hFFFF_FFFF);
    chk("R2 reserved bits zero", rdata_lo, 32'h0000_CF7F);

    // R4 directed: single rising edge, pulse after edge k+1 and one wide
    run_seg(mk_cfg(1, 0, 2'd1, 2'd0, 7'd5), 0, 0);
    @(negedge clk); gen_i[5] = 1'b1;
    @(negedge clk); chk("R4 no pulse after edge k", evt_lo, 0);
    chk("R11 busy at detection", req_lo, 1);
    @(negedge clk); chk("R4 pulse after edge k+1", evt_lo, 1);
    @(negedge clk); chk("R6 pulse one cycle", evt_lo, 0);
    chk("R11 request drops", req_lo, 0);
    // R5 directed
    run_seg(mk_cfg(1, 0, 2'd2, 2'd1, 7'd9), 0, 0);
    gen_i[9] = 1'b1;
    repeat (5) @(negedge clk);
    gen_i[9] = 1'b0;
    @(negedge clk); chk("R5 idle after edge k", evt_lo, 0);
    @(negedge clk); chk("R5 idle after edge k+1", evt_lo, 0);
    @(negedge clk); chk("R5 pulse after edge k+2", evt_lo, 1);
    @(negedge clk); chk("R6 resync pulse one cycle", evt_lo, 0);

    // directed corner segments
    run_seg(mk_cfg(1, 0, 2'd1, 2'd0, 7'd17), 0, 40);   // R6 rise
    run_seg(mk_cfg(1, 0, 2'd2, 2'd1, 7'd44), 0, 40);   // R6 fall
    run_seg(mk_cfg(1, 0, 2'd3, 2'd0, 7'd127), 0, 40);  // R6 both
    run_seg(mk_cfg(1, 0, 2'd0, 2'd0, 7'd2), 0, 40);    // R6 none
    run_seg(mk_cfg(1, 0, 2'd3, 2'd2, 7'd66), 0, 40);   // R7 ignores det
    run_seg(mk_cfg(0, 0, 2'd1, 2'd3, 7'd33), 0, 40);   // R9
    run_seg(mk_cfg(0, 1, 2'd3, 2'd0, 7'd0), 0, 40);    // R3
    run_seg(mk_cfg(0, 0, 2'd3, 2'd0, 7'd12), 1, 40);   // R10 stopped
    run_seg(mk_cfg(0, 1, 2'd3, 2'd1, 7'd12), 1, 40);   // R10 running
    run_seg(mk_cfg(0, 0, 2'd1, 2'd1, 7'd80), 0, 40);   // R11 always on

    for (int s = 0; s < 30; s++) begin
      logic [31:0] w;
      w = mk_cfg($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 4,
                 ($urandom % 8 == 0) ? 7'd0 : 7'($urandom));
      run_seg(w, ($urandom % 4) == 0, 50);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule